// File: doc/BRIEF.md
# Free-Running Snapshot Event Counter

The block counts rising edges of an already synchronized event stream into a wide binary counter. Nothing clears the counter during operation; only the chip reset does. A gate flip-flop decides which edges are counted. When the gate opens, the counter value is captured. When the gate closes, the captured value is subtracted from the live value. The difference, reduced to the result width, is presented with a one-cycle valid strobe.

The counter has four parts. A 4-bit front stage carries into a 16-bit middle stage. When the middle stage wraps, it does not carry straight into the upper part. It sets a sticky overflow flag instead, and that flag is consumed only on the periodic timebase tick. The flag then advances a chain of two 8-bit extension registers. Together these give 36 bits. Only the low 32 bits take part in the result.

The gate is a synchronous J/K-style flop with an active-high set control and an active-low clear control. The control logic normally moves both controls together, so the flop simply loads the new level, and the edge at which counting starts or stops is exact.

Top module: `evcnt_snapshot`

## Requirements
- R1: The gate flop loads the value of `gateJ` on the next clock edge whenever `gateJ` equals `gateKn`. With `gateJ`=0 and `gateKn`=1 it holds its state.
- R2: An event is one sample of `eventIn` at 1 whose previous-cycle sample was 0. It is counted only if the gate flop is 1 at that clock edge. When no event is counted, the front and middle stages do not change.
- R3: The front stage is 4 bits wide. Its wrap from all-ones carries one count into the 16-bit middle stage, so the low 20 bits form an exact binary count.
- R4: A wrap of the middle stage sets a sticky overflow flag. The flag stays set until a tick. The extension registers change only on a cycle with `tick`=1.
- R5: On a tick with the flag set, the extension value (extension register 0 low, register 1 high) increments by one in the same cycle that the flag clears. A middle-stage wrap in that same cycle leaves the flag set.
- R6: Only reset clears the counter. Each result is the live count when the gate closes minus the value captured when it opened, so events that arrive while the gate is closed never appear in a result.
- R7: Both captured values count a pending overflow flag as one extra unit of extension weight. A measurement that spans a middle-stage wrap with no tick in between is therefore still exact.
- R8: `resultOut` is the difference of the low RES_W bits of the two values, taken modulo 2^RES_W. A count larger than that range yields count mod 2^RES_W.
- R9: `resultValid` is high for exactly one cycle. That cycle is the one after the clock edge at which the gate flop falls, and `resultOut` carries the new difference in that cycle. `resultOut` otherwise holds its last value.
- R10: After reset, `resultValid` is 0, `resultOut` is 0, the gate is closed and the counter is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| eventIn | input | 1 | Synchronized event stream; rising edges are counted |
| gateJ | input | 1 | Gate set control (J) |
| gateKn | input | 1 | Gate clear control, active low (inverted K) |
| tick | input | 1 | One-cycle timebase pulse that consumes the overflow flag |
| resultOut | output | RES_W | End-minus-start event count |
| resultValid | output | 1 | One-cycle strobe marking a new result |

## Verification
Assertions check every cycle that the gate follows its controls. They also check that the front and middle stages are frozen whenever no event is counted, and that the extension moves only on a tick. On a tick with the flag pending, they check that the extension steps by one and the flag clears. Finally, they check that the valid strobe is a single cycle and that the result holds between strobes.

Only the bench's measurement scenarios can show that the results are exact counts. They cover edges sent while the gate is closed and measurements that cross a middle-stage wrap with ticks running. They also cover a wrap left pending with ticks stopped, counts that exceed the result range, and a gate held open through the hold code.

// File: rtl/evcnt_pkg.sv
package evcnt_pkg;

  // Strobes from the control to the datapath, one bit each, all single-cycle.
  typedef struct packed {
    logic countEn;   // count one event on this edge
    logic capStart;  // first cycle with the gate open: capture start value
    logic capEnd;    // first cycle with the gate closed: form the result
  } ctlStrobe_t;

endpackage

// File: rtl/evcnt_ctrl.sv
module evcnt_ctrl
  import evcnt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       eventIn,
  input  logic       gateJ,
  input  logic       gateKn,
  output ctlStrobe_t ctl
);

  logic gateQ;
  logic gatePrev;
  logic evPrev;
  logic gateNext;

  // J/K flop with inverted K: set on J, keep on Kn.
  always_comb begin
    gateNext = (gateJ & ~gateQ) | (gateKn & gateQ);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gateQ    <= 1'b0;
      gatePrev <= 1'b0;
      evPrev   <= 1'b0;
    end else begin
      gateQ    <= gateNext;
      gatePrev <= gateQ;
      evPrev   <= eventIn;
    end
  end

  always_comb begin
    ctl.countEn  = gateQ & eventIn & ~evPrev;
    ctl.capStart = gateQ & ~gatePrev;
    ctl.capEnd   = ~gateQ & gatePrev;
  end

  AST_GATE_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    (gateJ == gateKn) |=> (gateQ == $past(gateJ)));  // R1

  AST_GATE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!gateJ && gateKn) |=> $stable(gateQ));  // R1

endmodule

// File: rtl/evcnt_datapath.sv
module evcnt_datapath
  import evcnt_pkg::*;
#(
  parameter int FRONT_W = 4,
  parameter int MID_W   = 16,
  parameter int EXT_W   = 8,
  parameter int EXT_N   = 2,
  parameter int RES_W   = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  ctlStrobe_t       ctl,
  output logic [RES_W-1:0] resultOut,
  output logic             resultValid
);

  localparam int EXT_TOT = EXT_W * EXT_N;
  localparam int TOT_W   = FRONT_W + MID_W + EXT_TOT;

  logic [FRONT_W-1:0]            frontCnt;
  logic [MID_W-1:0]              midCnt;
  logic                          ovfFlag;
  logic [EXT_N-1:0][EXT_W-1:0]   extReg;
  logic [EXT_TOT-1:0]            extFlat;
  logic [EXT_N-1:0]              extCarry;
  logic                          frontWrap;
  logic                          midWrap;
  logic [RES_W-1:0]              resLive;
  logic [RES_W-1:0]              startSnap;

  assign frontWrap = ctl.countEn & (&frontCnt);
  assign midWrap   = frontWrap & (&midCnt);
  assign extFlat   = extReg;

  // Carry chain through the extension registers, advanced only by a consumed flag.
  assign extCarry[0] = ovfFlag & tick;
  for (genvar g = 1; g < EXT_N; g++) begin : gen_ext_carry
    assign extCarry[g] = extCarry[g-1] & (&extReg[g-1]);
  end

  // Live value, pending flag counted as one extension unit, truncated to the result width.
  assign resLive = RES_W'({extFlat + EXT_TOT'(ovfFlag), midCnt, frontCnt});

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frontCnt <= '0;
      midCnt   <= '0;
      ovfFlag  <= 1'b0;
      extReg   <= '0;
    end else begin
      if (ctl.countEn) frontCnt <= frontCnt + 1'b1;
      if (frontWrap)   midCnt   <= midCnt + 1'b1;
      if (midWrap)     ovfFlag  <= 1'b1;
      else if (tick)   ovfFlag  <= 1'b0;
      for (int i = 0; i < EXT_N; i++) begin
        if (extCarry[i]) extReg[i] <= extReg[i] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startSnap   <= '0;
      resultOut   <= '0;
      resultValid <= 1'b0;
    end else begin
      resultValid <= ctl.capEnd;
      if (ctl.capStart) startSnap <= resLive;
      if (ctl.capEnd)   resultOut <= resLive - startSnap;
    end
  end

  initial begin
    assert (RES_W <= TOT_W);
  end

  AST_FROZEN_CLOSED: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.countEn |=> ($stable(frontCnt) && $stable(midCnt)));  // R2

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !tick) |=> ovfFlag);  // R4

  AST_EXT_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> $stable(extFlat));  // R4

  AST_EXT_BUMP: assert property (@(posedge clk) disable iff (!rstN)
    (tick && ovfFlag) |=> (extFlat == EXT_TOT'($past(extFlat) + 1'b1)));  // R5

  AST_FLAG_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    (tick && ovfFlag && !midWrap) |=> !ovfFlag);  // R5

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);  // R9

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.capEnd |=> $stable(resultOut));  // R9

endmodule

// File: rtl/evcnt_snapshot.sv
module evcnt_snapshot
  import evcnt_pkg::*;
#(
  parameter int FRONT_W = 4,
  parameter int MID_W   = 16,
  parameter int EXT_W   = 8,
  parameter int EXT_N   = 2,
  parameter int RES_W   = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             eventIn,
  input  logic             gateJ,
  input  logic             gateKn,
  input  logic             tick,
  output logic [RES_W-1:0] resultOut,
  output logic             resultValid
);

  ctlStrobe_t ctl;

  evcnt_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .eventIn (eventIn),
    .gateJ   (gateJ),
    .gateKn  (gateKn),
    .ctl     (ctl)
  );

  evcnt_datapath #(
    .FRONT_W (FRONT_W),
    .MID_W   (MID_W),
    .EXT_W   (EXT_W),
    .EXT_N   (EXT_N),
    .RES_W   (RES_W)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .tick        (tick),
    .ctl         (ctl),
    .resultOut   (resultOut),
    .resultValid (resultValid)
  );

endmodule

// File: tb/evcnt_snapshot_tb_top.sv
module evcnt_snapshot_tb_top;

  // Narrow middle stage and result so wraps happen within a short run.
  localparam int FW = 4;
  localparam int MW = 4;
  localparam int EW = 8;
  localparam int EN = 2;
  localparam int RW = 12;
  localparam int RES_MOD = 1 << RW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic eventIn = 1'b0;
  logic gateJ = 1'b0;
  logic gateKn = 1'b0;
  logic tick = 1'b0;
  logic [RW-1:0] resultOut;
  logic resultValid;

  int checks = 0;
  int errors = 0;
  bit tickEn = 1'b0;
  bit done = 1'b0;

  logic [31:0] expQ[$];
  string tagQ[$];

  always #5 clk = ~clk;

  evcnt_snapshot #(
    .FRONT_W (FW), .MID_W (MW), .EXT_W (EW), .EXT_N (EN), .RES_W (RW)
  ) dut_i (
    .clk (clk), .rstN (rstN), .eventIn (eventIn), .gateJ (gateJ),
    .gateKn (gateKn), .tick (tick), .resultOut (resultOut), .resultValid (resultValid)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // Timebase: one-cycle tick every 8 cycles while enabled.
  initial begin
    forever begin
      repeat (7) @(negedge clk);
      tick = tickEn;
      @(negedge clk);
      tick = 1'b0;
    end
  end

  // Monitor: pops the scoreboard whenever a result appears.
  initial begin
    forever begin
      @(negedge clk);
      if (resultValid) begin
        if (expQ.size() == 0) chk("R9 unexpected valid", 32'd1, 32'd0);
        else chk(tagQ.pop_front(), 32'(resultOut), expQ.pop_front());
      end
    end
  end

  task automatic sendEvents(int n);
    repeat (n) begin
      @(negedge clk) eventIn = 1'b1;
      @(negedge clk) eventIn = 1'b0;
    end
  endtask

  task automatic openGate();
    @(negedge clk);
    gateJ  = 1'b1;
    gateKn = 1'b1;
  endtask

  // Closes the gate and checks the strobe lands exactly one cycle after the gate falls.
  task automatic closeGate(int n, string tag);
    @(negedge clk);
    expQ.push_back(32'(n % RES_MOD));
    tagQ.push_back(tag);
    gateJ  = 1'b0;
    gateKn = 1'b0;
    @(negedge clk);
    chk("R9 valid low while gate falls", 32'(resultValid), 32'd0);
    @(negedge clk);
    chk("R9 valid one cycle after gate falls", 32'(resultValid), 32'd1);
    @(negedge clk);
    chk("R9 valid single cycle", 32'(resultValid), 32'd0);
  endtask

  task automatic measure(int n, string tag);
    openGate();
    sendEvents(n);
    closeGate(n, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset valid", 32'(resultValid), 32'd0);
    chk("R10 reset result", 32'(resultOut), 32'd0);
    rstN = 1'b1;
    tickEn = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 valid after reset release", 32'(resultValid), 32'd0);

    measure(10, "R2 basic count");
    sendEvents(5);  // gate closed: must not appear in the next result
    measure(3, "R6 closed-gate events excluded");
    measure(40, "R3 front-stage carry");
    measure(600, "R4 R5 middle wraps with ticks");

    // Gate held open through the J=0/Kn=1 hold code.
    openGate();
    sendEvents(5);
    @(negedge clk);
    gateJ  = 1'b0;
    gateKn = 1'b1;
    sendEvents(5);
    closeGate(10, "R1 hold code keeps gate open");

    // Exactly one middle-stage wrap left pending: no ticks.
    tickEn = 1'b0;
    repeat (10) @(negedge clk);
    measure(256, "R7 pending flag in snapshot");
    tickEn = 1'b1;
    repeat (20) @(negedge clk);
    measure(20, "R5 flag consumed once");

    measure(5000, "R8 count beyond result range");
    measure(7, "R6 after many wraps");

    repeat (5) @(negedge clk);
    chk("R9 all results delivered", 32'(expQ.size()), 32'd0);
    chk("R9 result held", 32'(resultOut), 32'd7);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

endmodule